// File: doc/BRIEF.md
# SPI Serial EEPROM Command Engine

This block is an SPI slave (mode 0) that behaves like a 512-byte serial EEPROM. A host selects it by pulling the active-low chip select, sends an 8-bit instruction on the serial input, and clocks any address, data or status bytes through the same four wires. The ninth address bit is carried inside the read and write instructions. Reads stream without limit: the address advances after every byte and wraps from the top of the array back to zero.

All pins are sampled into the block's system clock domain through a short synchronizer, and every serial event is taken from an edge of the synchronized signals. The storage is a register array that is set to all 0xFF at reset. A countdown of a parameterized number of clock cycles stands in for the time that nonvolatile programming takes. A write or status write is committed only when chip select is released at the correct point. A write enable latch, a write-protect pin and a two-bit block protection level guard the array.

Top module: `spi_eeprom`

## Requirements
- R1: After reset the output enable is low, a status read returns 0x00 and every array byte reads 0xFF.
- R2: A read is the instruction 0000_A8_011 (binary, A8 in bit 3) followed by address byte A7..A0. After that byte, data leaves MSB first on `so`, and each bit is driven after a falling edge of `sck` so that it is valid at the next rising edge. The serial input is ignored while data streams out.
- R3: While chip select stays low, the read address increments after every byte and wraps from 0x1FF to 0x000.
- R4: A write is the instruction 0000_A8_010 (A8 in bit 3), then address byte A7..A0, then one data byte. It is programmed only when chip select rises while `sck` is low after exactly 24 rising edges. A release after fewer edges, or after any further rising edge, changes nothing.
- R5: Instruction 0x06 sets the write enable latch and 0x04 clears it. A write or status write issued with the latch clear is ignored. Every committed program cycle clears the latch.
- R6: While `wp_n` is low, neither a write nor a status write is committed.
- R7: Instruction 0x05 returns the status byte {4'b0000, level[1:0], enable latch, busy}, with busy in bit 0. While a program cycle runs it returns 0xFF.
- R8: A committed program cycle keeps the block busy for PROG_CYCLES clock cycles. While busy, every instruction other than 0x05 is ignored.
- R9: Instruction 0x01 followed by one byte loads bits 3:2 of that byte as the protection level. It is committed under the same release and guard rules as a write and starts a program cycle.
- R10: Level 1 protects 0x180..0x1FF, level 2 protects 0x100..0x1FF, level 3 protects the whole array, and level 0 protects nothing. A write to a protected byte leaves it unchanged.
- R11: `so_oe` is high only while read or status data is being driven, and it drops when chip select rises. Any undefined instruction is ignored until chip select goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than `sck` |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock, mode 0 |
| si | input | 1 | Serial data in, sampled on rising `sck` |
| wp_n | input | 1 | Active-low write protect |
| so | output | 1 | Serial data out, changed after falling `sck` |
| so_oe | output | 1 | High while `so` carries data; otherwise the pin floats |

## Verification
Writes are tried with both values of the high address bit, so a lost A8 shows up as data at the wrong half of the array. Chip-select releases are placed one bit early, exactly on time and one clock late, which isolates the commit window. A read started two bytes below the top of the array checks both the increment and the wrap to zero. Each protection level is probed with writes just inside and just outside its boundary. Status reads taken during a program cycle, combined with enable, disable and write-protect patterns, show whether the guards and the busy lockout work.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;

    localparam int ADDR_W = 9;
    localparam int DEPTH  = 1 << ADDR_W;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WRSR = 8'h01;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_CMD,
        PH_ADDR,
        PH_DATA,
        PH_SRIN,
        PH_ARMED,
        PH_RDOUT,
        PH_STOUT,
        PH_SKIP
    } phase_e;

    typedef enum logic [1:0] {
        K_NONE,
        K_READ,
        K_WRITE,
        K_WRSR
    } kind_e;

    function automatic logic is_read_op(input logic [7:0] b);
        return (b[7:4] == 4'h0) && (b[2:0] == 3'b011);
    endfunction

    function automatic logic is_write_op(input logic [7:0] b);
        return (b[7:4] == 4'h0) && (b[2:0] == 3'b010);
    endfunction

    // top2 holds the two most significant address bits
    function automatic logic blk_locked(input logic [1:0] lvl, input logic [1:0] top2);
        case (lvl)
            2'd0:    return 1'b0;
            2'd1:    return top2 == 2'b11;
            2'd2:    return top2[1];
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/spi_eeprom_sync.sv
module spi_eeprom_sync #(
    parameter int           W       = 4,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_cur,
    output logic [W-1:0] q_prev
);

    logic [W-1:0] pipe_q [STAGES+1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k <= STAGES; k++) pipe_q[k] <= RST_VAL;
        end else begin
            pipe_q[0] <= d_in;
            for (int k = 1; k <= STAGES; k++) pipe_q[k] <= pipe_q[k-1];
        end
    end

    assign q_cur  = pipe_q[STAGES-1];
    assign q_prev = pipe_q[STAGES];

endmodule

// File: rtl/spi_eeprom_store.sv
module spi_eeprom_store
    import spi_eeprom_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);

    logic [7:0] cell_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cell_q[i] <= 8'hFF;
        end else if (we) begin
            cell_q[waddr] <= wdata;
        end
    end

    assign rdata = cell_q[raddr];

endmodule

// File: rtl/spi_eeprom_core.sv
module spi_eeprom_core
    import spi_eeprom_pkg::*;
#(
    parameter int PROG_CYCLES = 50000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              sck_s,
    input  logic              si_s,
    input  logic              wp_s,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              so,
    output logic              so_oe,
    output logic              busy
);

    localparam int CNT_W = $clog2(PROG_CYCLES + 1);
    localparam logic [CNT_W-1:0] PROG_LOAD = CNT_W'(PROG_CYCLES);

    typedef struct packed {
        phase_e            phase;
        kind_e             kind;
        logic [2:0]        bitc;
        logic [7:0]        sh;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        wdat;
        logic [2:0]        outc;
        logic [7:0]        outsh;
        logic              so;
        logic              oe;
        logic              wel;
        logic [1:0]        lvl;
        logic [CNT_W-1:0]  bcnt;
    } core_t;

    core_t st_q, st_d;

    logic       busy_now;
    logic [7:0] status;
    logic [7:0] byte_in;
    logic [7:0] out_src;
    logic       we_d;

    always_comb begin
        st_d     = st_q;
        we_d     = 1'b0;
        busy_now = (st_q.bcnt != '0);
        status   = busy_now ? 8'hFF : {4'b0000, st_q.lvl, st_q.wel, 1'b0};
        byte_in  = {st_q.sh[6:0], si_s};
        out_src  = (st_q.phase == PH_RDOUT) ? rd_data : status;

        if (busy_now) st_d.bcnt = st_q.bcnt - 1'b1;

        if (cs_fall) begin
            st_d.phase = PH_CMD;
            st_d.kind  = K_NONE;
            st_d.bitc  = '0;
            st_d.outc  = '0;
            st_d.oe    = 1'b0;
            st_d.so    = 1'b0;
        end else if (cs_rise) begin
            if (st_q.phase == PH_ARMED && !sck_s && st_q.wel && wp_s && !busy_now) begin
                if (st_q.kind == K_WRITE &&
                    !blk_locked(st_q.lvl, st_q.addr[ADDR_W-1 -: 2])) begin
                    we_d      = 1'b1;
                    st_d.bcnt = PROG_LOAD;
                    st_d.wel  = 1'b0;
                end else if (st_q.kind == K_WRSR) begin
                    st_d.lvl  = st_q.wdat[3:2];
                    st_d.bcnt = PROG_LOAD;
                    st_d.wel  = 1'b0;
                end
            end
            st_d.phase = PH_IDLE;
            st_d.oe    = 1'b0;
        end else if (st_q.phase != PH_IDLE) begin
            if (sck_rise) begin
                st_d.sh   = byte_in;
                st_d.bitc = st_q.bitc + 1'b1;
                if (st_q.phase == PH_ARMED) begin
                    st_d.phase = PH_SKIP;
                end else if (st_q.bitc == 3'd7) begin
                    case (st_q.phase)
                        PH_CMD: begin
                            if (busy_now && byte_in != OP_RDSR) begin
                                st_d.phase = PH_SKIP;
                            end else if (is_read_op(byte_in)) begin
                                st_d.addr[ADDR_W-1] = byte_in[3];
                                st_d.kind  = K_READ;
                                st_d.phase = PH_ADDR;
                            end else if (is_write_op(byte_in)) begin
                                st_d.addr[ADDR_W-1] = byte_in[3];
                                st_d.kind  = K_WRITE;
                                st_d.phase = PH_ADDR;
                            end else if (byte_in == OP_WREN) begin
                                st_d.wel   = 1'b1;
                                st_d.phase = PH_SKIP;
                            end else if (byte_in == OP_WRDI) begin
                                st_d.wel   = 1'b0;
                                st_d.phase = PH_SKIP;
                            end else if (byte_in == OP_RDSR) begin
                                st_d.outc  = '0;
                                st_d.phase = PH_STOUT;
                            end else if (byte_in == OP_WRSR) begin
                                st_d.kind  = K_WRSR;
                                st_d.phase = PH_SRIN;
                            end else begin
                                st_d.phase = PH_SKIP;
                            end
                        end
                        PH_ADDR: begin
                            st_d.addr[7:0] = byte_in;
                            st_d.outc      = '0;
                            st_d.phase     = (st_q.kind == K_READ) ? PH_RDOUT : PH_DATA;
                        end
                        PH_DATA, PH_SRIN: begin
                            st_d.wdat  = byte_in;
                            st_d.phase = PH_ARMED;
                        end
                        default: ;
                    endcase
                end
            end
            if (sck_fall && (st_q.phase == PH_RDOUT || st_q.phase == PH_STOUT)) begin
                if (st_q.outc == '0) begin
                    st_d.so    = out_src[7];
                    st_d.outsh = {out_src[6:0], 1'b0};
                end else begin
                    st_d.so    = st_q.outsh[7];
                    st_d.outsh = {st_q.outsh[6:0], 1'b0};
                end
                st_d.outc = st_q.outc + 1'b1;
                st_d.oe   = 1'b1;
                if (st_q.outc == 3'd7 && st_q.phase == PH_RDOUT)
                    st_d.addr = st_q.addr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
            st_q.kind  <= K_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_addr = st_q.addr;
    assign wr_en   = we_d;
    assign wr_addr = st_q.addr;
    assign wr_data = st_q.wdat;
    assign so      = st_q.so;
    assign so_oe   = st_q.oe;
    assign busy    = busy_now;

endmodule

// File: rtl/spi_eeprom.sv
module spi_eeprom
    import spi_eeprom_pkg::*;
#(
    parameter int PROG_CYCLES = 50000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic wp_n,
    output logic so,
    output logic so_oe
);

    localparam int PIN_W = 4;
    localparam logic [PIN_W-1:0] PIN_RST = 4'b0001;

    logic [PIN_W-1:0] pin_cur, pin_prev;
    logic             cs_fall, cs_rise, sck_rise, sck_fall;
    logic             sck_s, si_s, wp_s;
    logic             mem_we, busy;
    logic [ADDR_W-1:0] mem_raddr, mem_waddr;
    logic [7:0]       mem_rdata, mem_wdata;

    spi_eeprom_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST)
    ) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_in   ({wp_n, si, sck, cs_n}),
        .q_cur  (pin_cur),
        .q_prev (pin_prev)
    );

    assign cs_fall  =  pin_prev[0] & ~pin_cur[0];
    assign cs_rise  = ~pin_prev[0] &  pin_cur[0];
    assign sck_rise = ~pin_prev[1] &  pin_cur[1];
    assign sck_fall =  pin_prev[1] & ~pin_cur[1];
    assign sck_s    = pin_cur[1];
    assign si_s     = pin_cur[2];
    assign wp_s     = pin_cur[3];

    spi_eeprom_core #(
        .PROG_CYCLES (PROG_CYCLES)
    ) i_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .sck_s    (sck_s),
        .si_s     (si_s),
        .wp_s     (wp_s),
        .rd_data  (mem_rdata),
        .rd_addr  (mem_raddr),
        .wr_en    (mem_we),
        .wr_addr  (mem_waddr),
        .wr_data  (mem_wdata),
        .so       (so),
        .so_oe    (so_oe),
        .busy     (busy)
    );

    spi_eeprom_store i_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

endmodule

// File: rtl/spi_eeprom_chk.sv
module spi_eeprom_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_fall,
    input logic cs_rise,
    input logic sck_fall,
    input logic sck_s,
    input logic wp_s,
    input logic mem_we,
    input logic busy,
    input logic so,
    input logic so_oe
);

    // R4: the array is written only on a chip-select release with sck low
    assert_commit_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (cs_rise && !sck_s));

    // R8: a committed write starts the busy period
    assert_busy_starts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> busy);

    // R8: no array write while a program cycle runs
    assert_no_write_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !mem_we);

    // R6: write protect pin blocks array writes
    assert_wp_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_s |-> !mem_we);

    // R11: output enable drops after release
    assert_oe_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !so_oe);

    // R2: serial output only moves after a falling sck or a new selection
    assert_so_changes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sck_fall && !cs_fall) |=> $stable(so));

endmodule

bind spi_eeprom spi_eeprom_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_fall  (cs_fall),
    .cs_rise  (cs_rise),
    .sck_fall (sck_fall),
    .sck_s    (sck_s),
    .wp_s     (wp_s),
    .mem_we   (mem_we),
    .busy     (busy),
    .so       (so),
    .so_oe    (so_oe)
);

// File: tb/test_spi_eeprom.sv
module test_spi_eeprom;

    localparam time CLK_PERIOD = 10ns;
    localparam int  HALF       = 8;
    localparam int  PROG       = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic si = 1'b0;
    logic wp_n = 1'b1;
    logic so, so_oe;

    int checks = 0;
    int errors = 0;
    logic [7:0] mdl [512];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_eeprom #(.PROG_CYCLES(PROG)) i_spi_eeprom (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
        .si(si), .wp_n(wp_n), .so(so), .so_oe(so_oe)
    );

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel();
        cs_n = 1'b0;
        waitc(HALF);
    endtask

    task automatic desel();
        waitc(HALF);
        cs_n = 1'b1;
        waitc(2 * HALF);
    endtask

    task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i > 7 - n; i--) begin
            si = tx[i];
            waitc(HALF);
            rx[i] = so;
            sck = 1'b1;
            waitc(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        bits(tx, 8, rx);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] r;
        sel(); xfer(op, r); desel();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] r;
        sel(); xfer(8'h05, r); xfer(8'h00, s); desel();
    endtask

    task automatic rd1(input logic [8:0] a, output logic [7:0] d);
        logic [7:0] r;
        sel(); xfer({4'h0, a[8], 3'b011}, r); xfer(a[7:0], r); xfer(8'h00, d); desel();
    endtask

    task automatic wr(input logic [8:0] a, input logic [7:0] d, input bit ok);
        logic [7:0] r;
        cmd1(8'h06);
        sel(); xfer({4'h0, a[8], 3'b010}, r); xfer(a[7:0], r); xfer(d, r); desel();
        waitc(PROG + 50);
        if (ok) mdl[a] = d;
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] r;
        cmd1(8'h06);
        sel(); xfer(8'h01, r); xfer(v, r); desel();
        waitc(PROG + 50);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk8("R1 oe after reset", {7'd0, so_oe}, 8'h00);
        rdsr(v); chk8("R1 R7 status after reset", v, 8'h00);
        rd1(9'h000, v); chk8("R1 byte 0x000", v, 8'hFF);
        rd1(9'h1A5, v); chk8("R1 byte 0x1A5", v, 8'hFF);
    endtask

    task automatic t_write_basic();
        logic [7:0] v;
        cmd1(8'h06);
        rdsr(v); chk8("R5 R7 latch set", v, 8'h02);
        cmd1(8'h04);
        rdsr(v); chk8("R5 latch cleared", v, 8'h00);
        wr(9'h0A5, 8'h3C, 1);
        rd1(9'h0A5, v); chk8("R4 write low half", v, 8'h3C);
        wr(9'h15A, 8'hC3, 1);
        rd1(9'h15A, v); chk8("R2 R4 A8 write", v, 8'hC3);
        rd1(9'h05A, v); chk8("R2 A8 alias untouched", v, 8'hFF);
        rdsr(v); chk8("R5 latch cleared by program", v, 8'h00);
    endtask

    task automatic t_busy();
        logic [7:0] v, r;
        cmd1(8'h06);
        sel(); xfer(8'h02, r); xfer(8'h10, r); xfer(8'h77, r); desel();
        rdsr(v); chk8("R7 status while busy", v, 8'hFF);
        cmd1(8'h06);
        waitc(PROG + 50);
        mdl[9'h010] = 8'h77;
        rdsr(v); chk8("R8 enable ignored while busy", v, 8'h00);
        rd1(9'h010, v); chk8("R8 busy write landed", v, 8'h77);
    endtask

    task automatic t_no_enable();
        logic [7:0] v, r;
        sel(); xfer(8'h02, r); xfer(8'h20, r); xfer(8'h11, r); desel();
        waitc(PROG + 50);
        rd1(9'h020, v); chk8("R5 write without latch", v, 8'hFF);
    endtask

    task automatic t_release();
        logic [7:0] v, r;
        cmd1(8'h06);
        sel(); xfer(8'h02, r); xfer(8'h30, r); bits(8'h55, 7, r); desel();
        waitc(PROG + 50);
        rd1(9'h030, v); chk8("R4 early release", v, 8'hFF);
        rdsr(v); chk8("R4 latch kept after early release", v, 8'h02);
        sel(); xfer(8'h02, r); xfer(8'h30, r); xfer(8'h55, r); bits(8'h00, 1, r); desel();
        waitc(PROG + 50);
        rd1(9'h030, v); chk8("R4 extra clock release", v, 8'hFF);
        cmd1(8'h04);
    endtask

    task automatic t_wp();
        logic [7:0] v;
        wp_n = 1'b0;
        wr(9'h040, 8'h66, 0);
        rd1(9'h040, v); chk8("R6 write with wp low", v, 8'hFF);
        wrsr(8'h0C);
        cmd1(8'h04);
        rdsr(v); chk8("R6 status write with wp low", v, 8'h00);
        wp_n = 1'b1;
    endtask

    task automatic t_seq();
        logic [7:0] v, r;
        wr(9'h1FF, 8'h9A, 1);
        wr(9'h000, 8'h5B, 1);
        sel();
        xfer(8'h0B, r); xfer(8'hFE, r);
        xfer(8'hA5, v); chk8("R3 byte 0x1FE", v, mdl[9'h1FE]);
        xfer(8'h5A, v); chk8("R3 byte 0x1FF", v, mdl[9'h1FF]);
        xfer(8'hFF, v); chk8("R3 wrap to 0x000", v, mdl[9'h000]);
        xfer(8'h00, v); chk8("R3 byte 0x001", v, mdl[9'h001]);
        chk8("R11 oe while streaming", {7'd0, so_oe}, 8'h01);
        desel();
        chk8("R11 oe after release", {7'd0, so_oe}, 8'h00);
    endtask

    task automatic t_protect();
        logic [7:0] v;
        wrsr(8'h04);
        rdsr(v); chk8("R9 level 1 loaded", v, 8'h04);
        wr(9'h180, 8'h12, 0); rd1(9'h180, v); chk8("R10 level1 blocks 0x180", v, mdl[9'h180]);
        cmd1(8'h04);
        wr(9'h17F, 8'h13, 1); rd1(9'h17F, v); chk8("R10 level1 allows 0x17F", v, 8'h13);
        wrsr(8'h08);
        wr(9'h100, 8'h14, 0); rd1(9'h100, v); chk8("R10 level2 blocks 0x100", v, mdl[9'h100]);
        cmd1(8'h04);
        wr(9'h0FF, 8'h15, 1); rd1(9'h0FF, v); chk8("R10 level2 allows 0x0FF", v, 8'h15);
        wrsr(8'h0C);
        wr(9'h000, 8'h16, 0); rd1(9'h000, v); chk8("R10 level3 blocks 0x000", v, mdl[9'h000]);
        cmd1(8'h04);
        wrsr(8'h00);
        rdsr(v); chk8("R9 level cleared", v, 8'h00);
    endtask

    task automatic t_unknown();
        logic [7:0] v, r;
        int seen;
        seen = 0;
        sel();
        xfer(8'h0E, r);
        xfer(8'h03, r); if (so_oe) seen++;
        xfer(8'h00, r); if (so_oe) seen++;
        xfer(8'h00, r); if (so_oe) seen++;
        desel();
        chk8("R11 undefined opcode keeps oe low", 8'(seen), 8'h00);
        rd1(9'h0A5, v); chk8("R11 engine usable after undefined", v, mdl[9'h0A5]);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mdl[i] = 8'hFF;
        waitc(5);
        rst_n = 1'b1;
        waitc(5);
        t_reset();
        t_write_basic();
        t_busy();
        t_no_enable();
        t_release();
        t_wp();
        t_seq();
        t_protect();
        t_unknown();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule